// File: doc/BRIEF.md
# Serial Transmitter with Empty and Done Flags

This block sends bytes as asynchronous serial frames. It has a host-side data register, a separate frame shifter and two status flags. The empty flag says the data register can take a new byte. The done flag says the line has gone quiet with nothing queued. A byte is queued in two steps: the host writes it, then clears the empty flag. A single-cycle DMA strobe can do both steps at once. An interrupt output asks for the next byte while the empty flag is set and its enable bit is on.

A line-enable bit decides what drives the serial pin. When the bit is set, the shifter drives the pin, and the first thing it sends is one frame time of marks. When the bit is clear, a small port register drives the pin: a direction bit and a value bit. Setting the direction to 1 and the value to 0 holds the line low, which is how a break is sent. Clearing the enable bit in the middle of a frame abandons that frame at once. Bit timing comes from an external baud-tick strobe.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset the status register (address 2) reads empty = 1 (bit 0) and done = 1 (bit 1), the control register (address 0) reads 0, `txd` is 1 and `txi` is 0.
- R2: With line enable (control bit 0) clear, `txd` follows the port value bit (address 3, bit 1) when the port direction bit (address 3, bit 0) is 1, and is 1 when the direction bit is 0. With line enable set, the port register has no effect on `txd`.
- R3: After line enable goes from 0 to 1, `txd` stays 1 for FRAME_BITS × OVERSAMPLE baud ticks before any start bit, even if a byte is already queued.
- R4: A frame is a 0 start bit, DATA_W data bits sent least significant bit first, and a 1 stop bit. Each bit lasts OVERSAMPLE baud ticks.
- R5: A write to the data register (address 1) on its own does not start a transfer. A later status write with bit 0 = 0 clears the empty flag and queues the byte.
- R6: Writing 1 to status bit 0 leaves the flag unchanged. Writing 0 to it when no data write has happened since the last commit leaves the empty flag at 1 and sends no frame.
- R7: When a queued byte moves into the shifter, the empty flag returns to 1. If a byte is queued when a stop bit ends, its start bit follows with no idle gap.
- R8: The done flag goes to 1 at the end of a stop bit only if the empty flag is 1 at that point. It goes to 0 whenever the empty flag is cleared.
- R9: `txi` is 1 exactly while the empty flag is 1 and the interrupt enable (control bit 1) is set.
- R10: A one-cycle `dma_we` pulse loads `dma_wdata` into the data register and clears the empty flag, with no status write needed. The byte is then sent.
- R11: Clearing line enable in the middle of a frame stops it at once: the pin goes to the port register on the next cycle, and both flags read 1. The frame does not resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 status, 3 port |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| dma_we | input | 1 | One-cycle DMA write: loads the byte and queues it |
| dma_wdata | input | DATA_W | DMA write data |
| baud_tick | input | 1 | One-cycle bit-timing strobe; OVERSAMPLE ticks make one bit |
| txi | output | 1 | Transmit-data-empty interrupt request |
| txd | output | 1 | Serial line |

## Verification
The bench builds the block with DATA_W = 8 and OVERSAMPLE = 4, and holds the baud tick high on every cycle. A bit then lasts four clocks and a frame forty. This keeps several things short enough to measure to the exact cycle: the mark frame after enabling, the zero-gap hand-off between two queued bytes, the done-flag timing at a stop bit, and an abort partway through the data bits. Mid-bit sampling of `txd` rebuilds each byte and its start and stop bits.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    SH_OFF  = 2'd0,
    SH_MARK = 2'd1,
    SH_IDLE = 2'd2,
    SH_SEND = 2'd3
  } sh_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_PORT = 2'd3;
endpackage

// File: rtl/txf_ctrl_regs.sv
module txf_ctrl_regs
  import txf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [1:0] ctl_bits,
  output logic       line_en,
  output logic       irq_en,
  output logic       port_dir,
  output logic       port_val,
  output logic       data_we,
  output logic       stat_we,
  output logic       abort
);
  logic ctrl_we, port_we;
  logic en_q, en_d, ie_q, ie_d, dir_q, dir_d, val_q, val_d;

  always_comb begin
    ctrl_we = bus_we && (bus_addr == ADDR_CTRL);
    port_we = bus_we && (bus_addr == ADDR_PORT);
    data_we = bus_we && (bus_addr == ADDR_DATA);
    stat_we = bus_we && (bus_addr == ADDR_STAT);
    abort   = ctrl_we && !ctl_bits[0] && en_q;
    en_d    = ctl_bits[0];
    ie_d    = ctl_bits[1];
    dir_d   = ctl_bits[0];
    val_d   = ctl_bits[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q <= en_d;
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      val_q <= 1'b1;
    end else if (port_we) begin
      dir_q <= dir_d;
      val_q <= val_d;
    end
  end

  assign line_en  = en_q;
  assign irq_en   = ie_q;
  assign port_dir = dir_q;
  assign port_val = val_q;

  // R11: an abort request always leaves the line disabled
  assert_abort_disables_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !en_q);
endmodule

// File: rtl/txf_flags.sv
module txf_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              load,
  input  logic              frame_done,
  input  logic              abort,
  output logic              tdre,
  output logic              tend,
  output logic [DATA_W-1:0] hold_data
);
  logic tdre_q, tdre_d, tend_q, tend_d, fresh_q, fresh_d;
  logic commit, clear_req, hold_en;
  logic [DATA_W-1:0] hold_q, hold_d;

  always_comb begin
    commit    = stat_we && !wdata[0] && fresh_q && tdre_q;
    clear_req = commit || dma_we;

    if (abort)          tdre_d = 1'b1;
    else if (clear_req) tdre_d = 1'b0;
    else if (load)      tdre_d = 1'b1;
    else                tdre_d = tdre_q;

    if (abort)                     tend_d = 1'b1;
    else if (clear_req)            tend_d = 1'b0;
    else if (frame_done && tdre_q) tend_d = 1'b1;
    else                           tend_d = tend_q;

    if (abort || dma_we) fresh_d = 1'b0;
    else if (data_we)    fresh_d = 1'b1;
    else if (commit)     fresh_d = 1'b0;
    else                 fresh_d = fresh_q;

    hold_en = dma_we || data_we;
    hold_d  = dma_we ? dma_wdata : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdre_q  <= 1'b1;
      tend_q  <= 1'b1;
      fresh_q <= 1'b0;
    end else begin
      tdre_q  <= tdre_d;
      tend_q  <= tend_d;
      fresh_q <= fresh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign tdre      = tdre_q;
  assign tend      = tend_q;
  assign hold_data = hold_q;

  assert_load_sets_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear_req) |=> tdre_q);
  assert_done_needs_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tend_q |-> tdre_q);
  assert_abort_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (tdre_q && tend_q));
  assert_stale_commit_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && tdre_q && !fresh_q && !dma_we) |=> tdre_q);
  assert_dma_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_we && !abort) |=> !tdre_q);
endmodule

// File: rtl/txf_shifter.sv
module txf_shifter
  import txf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              baud_tick,
  input  logic              tdre,
  input  logic [DATA_W-1:0] hold_data,
  output logic              load,
  output logic              frame_done,
  output logic              line_bit
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  sh_state_e state_q, state_d;
  logic [CNT_W-1:0]      tick_q, tick_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic tick_last, bit_end, frame_end, counting;

  always_comb begin
    tick_last  = (tick_q == CNT_W'(OVERSAMPLE - 1));
    bit_end    = baud_tick && tick_last;
    frame_end  = bit_end && (bit_q == BIT_W'(FRAME_BITS - 1));
    counting   = (state_q == SH_MARK) || (state_q == SH_SEND);
    load       = en && !tdre && ((state_q == SH_IDLE) || (counting && frame_end));
    frame_done = en && (state_q == SH_SEND) && frame_end;
    line_bit   = (state_q == SH_SEND) ? sh_q[0] : 1'b1;
  end

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    if (!en) begin
      state_d = SH_OFF;
      tick_d  = '0;
      bit_d   = '0;
      sh_d    = '1;
    end else begin
      case (state_q)
        SH_OFF: begin
          state_d = SH_MARK;
          tick_d  = '0;
          bit_d   = '0;
        end
        SH_MARK, SH_SEND: begin
          if (baud_tick) begin
            if (tick_last) begin
              tick_d = '0;
              if (frame_end) begin
                bit_d = '0;
                if (load) begin
                  state_d = SH_SEND;
                  sh_d    = {1'b1, hold_data, 1'b0};
                end else begin
                  state_d = SH_IDLE;
                  sh_d    = '1;
                end
              end else begin
                bit_d = bit_q + 1'b1;
                sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
              end
            end else begin
              tick_d = tick_q + 1'b1;
            end
          end
        end
        SH_IDLE: begin
          if (load) begin
            state_d = SH_SEND;
            tick_d  = '0;
            bit_d   = '0;
            sh_d    = {1'b1, hold_data, 1'b0};
          end
        end
        default: state_d = SH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_OFF;
      tick_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '1;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_SEND && bit_q == '0) |-> !line_bit);
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_SEND && bit_q == BIT_W'(FRAME_BITS - 1)) |-> line_bit);
  assert_enable_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == SH_OFF) |=> (state_q == SH_MARK));
  assert_mark_line_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_MARK) |-> line_bit);
  assert_drop_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == SH_OFF));
endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
  import txf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              baud_tick,
  output logic              txi,
  output logic              txd
);
  logic rst_meta_q, rst_sync_q;
  logic line_en, irq_en, port_dir, port_val, data_we, stat_we, abort;
  logic tdre, tend, load, frame_done, line_bit;
  logic [DATA_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  txf_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_sync_q), .bus_we(bus_we), .bus_addr(bus_addr),
    .ctl_bits(bus_wdata[1:0]), .line_en(line_en), .irq_en(irq_en),
    .port_dir(port_dir), .port_val(port_val), .data_we(data_we),
    .stat_we(stat_we), .abort(abort)
  );

  txf_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_sync_q), .data_we(data_we), .stat_we(stat_we),
    .wdata(bus_wdata), .dma_we(dma_we), .dma_wdata(dma_wdata), .load(load),
    .frame_done(frame_done), .abort(abort), .tdre(tdre), .tend(tend),
    .hold_data(hold_data)
  );

  txf_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst_n(rst_sync_q), .en(line_en), .baud_tick(baud_tick),
    .tdre(tdre), .hold_data(hold_data), .load(load),
    .frame_done(frame_done), .line_bit(line_bit)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: bus_rdata[1:0] = {irq_en, line_en};
      ADDR_DATA: bus_rdata      = hold_data;
      ADDR_STAT: bus_rdata[1:0] = {tend, tdre};
      default:   bus_rdata[1:0] = {port_val, port_dir};
    endcase
  end

  assign txi = tdre && irq_en;
  assign txd = line_en ? line_bit : (port_dir ? port_val : 1'b1);

  // R8: done may only rise when a frame finished with nothing queued
  assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(tend) |-> ($past(frame_done) || $past(abort)));
endmodule

// File: tb/tb_serial_tx_unit.sv
`timescale 1ns/1ps
module tb_serial_tx_unit;
  localparam int DW  = 8;
  localparam int OS  = 4;
  localparam int FB  = DW + 2;
  localparam int HALF = OS / 2 - 1;

  logic clk, rst_n, bus_we, dma_we, baud_tick;
  logic [1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, dma_wdata;
  logic txi, txd;
  int checks, failures;
  bit finished;

  serial_tx_unit #(.DATA_W(DW), .OVERSAMPLE(OS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_we(dma_we),
    .dma_wdata(dma_wdata), .baud_tick(baud_tick), .txi(txi), .txd(txd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic rx_frame(output logic [DW-1:0] b, output int waited, output bit ok);
    logic s0, s1;
    waited = 0;
    while (txd !== 1'b0 && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    repeat (HALF) @(negedge clk);
    s0 = txd;
    for (int i = 0; i < DW; i++) begin
      repeat (OS) @(negedge clk);
      b[i] = txd;
    end
    repeat (OS) @(negedge clk);
    s1 = txd;
    ok = (s0 == 1'b0) && (s1 == 1'b1);
  endtask

  task automatic t_reset;
    int v;
    chk("R1 txd", int'(txd), 1);
    chk("R1 txi", int'(txi), 0);
    rd(2'd2, v); chk("R1 status", v, 3);
    rd(2'd0, v); chk("R1 control", v, 0);
  endtask

  task automatic t_port_break;
    wr(2'd3, 8'h01); chk("R2 break low", int'(txd), 0);
    wr(2'd3, 8'h03); chk("R2 port high", int'(txd), 1);
    wr(2'd3, 8'h02); chk("R2 dir0 idle", int'(txd), 1);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_preamble_first;
    int v, w; logic [DW-1:0] b; bit ok;
    wr(2'd1, 8'hA5);
    rd(2'd2, v); chk("R5 data alone", v & 1, 1);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R5 commit clears", v & 1, 0);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R6 write one ignored", v & 1, 0);
    wr(2'd0, 8'h01);
    chk("R2 port ignored when enabled", int'(txd), 1);
    rx_frame(b, w, ok);
    chk("R3 mark frame length", w, FB * OS + 1);
    chk("R4 byte A5", int'(b), 'hA5);
    chk("R4 start/stop", int'(ok), 1);
    rd(2'd2, v); chk("R8 done low in stop", v, 1);
    repeat (OS - HALF) @(negedge clk);
    rd(2'd2, v); chk("R8 done after stop", v, 3);
  endtask

  task automatic t_stale_commit;
    int v, lows;
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R6 stale commit", v, 3);
    lows = 0;
    repeat (12 * OS) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R6 no frame sent", lows, 0);
  endtask

  task automatic t_back_to_back;
    int v, w, w2; logic [DW-1:0] b, b2; bit ok, ok2;
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'h00);
    fork
      rx_frame(b, w, ok);
      begin
        wr(2'd1, 8'hC3);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R8 done cleared with empty", v, 0);
      end
    join
    chk("R4 byte 3C", int'(b), 'h3C);
    rx_frame(b2, w2, ok2);
    chk("R7 no gap", w2, OS - HALF);
    chk("R7 byte C3", int'(b2), 'hC3);
    chk("R7 frame ok", int'(ok && ok2), 1);
    repeat (OS - HALF) @(negedge clk);
    rd(2'd2, v); chk("R8 done after last", v, 3);
  endtask

  task automatic t_irq;
    int w; logic [DW-1:0] b; bit ok;
    chk("R9 txi off without enable", int'(txi), 0);
    wr(2'd0, 8'h03);
    chk("R9 txi on", int'(txi), 1);
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'h00);
    chk("R9 txi drops on commit", int'(txi), 0);
    @(negedge clk);
    chk("R9 txi back after transfer", int'(txi), 1);
    rx_frame(b, w, ok);
    chk("R4 byte 5A", int'(b), 'h5A);
    repeat (OS) @(negedge clk);
  endtask

  task automatic t_dma;
    int v, w; logic [DW-1:0] b; bit ok;
    @(negedge clk);
    dma_we = 1'b1; dma_wdata = 8'h96;
    @(negedge clk);
    dma_we = 1'b0;
    rd(2'd2, v); chk("R10 dma clears empty", v, 0);
    rx_frame(b, w, ok);
    chk("R10 dma byte sent", int'(b), 'h96);
    chk("R10 frame ok", int'(ok), 1);
    repeat (OS) @(negedge clk);
  endtask

  task automatic t_abort;
    int v, w, lows;
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    w = 0;
    while (txd !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
    repeat (3 * OS) @(negedge clk);
    chk("R11 mid-frame low", int'(txd), 0);
    wr(2'd0, 8'h02);
    chk("R11 pin to port", int'(txd), 1);
    rd(2'd2, v); chk("R11 flags forced", v, 3);
    chk("R9 txi after abort", int'(txi), 1);
    lows = 0;
    repeat (12 * OS) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R11 frame not resumed", lows, 0);
    wr(2'd3, 8'h01); chk("R2 break after abort", int'(txd), 0);
    wr(2'd3, 8'h00); chk("R2 release break", int'(txd), 1);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    dma_we = 1'b0; dma_wdata = '0; baud_tick = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_port_break();
    t_preamble_first();
    t_stale_commit();
    t_back_to_back();
    t_irq();
    t_dma();
    t_abort();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule